// File: doc/BRIEF.md
# Seven-to-One Video Link Deframer

This block recovers pixels from a four-lane serial video link whose bits have already been sampled, one bit per lane per cycle, on a clock running at seven times the pixel rate. A fifth lane carries a framing clock whose level over each pixel period forms a fixed seven-bit shape. The deframer finds the pixel boundary from that shape and collects seven bits from every data lane into a 28-bit frame word. It then splits the word into 8-bit red, green and blue values plus horizontal sync, vertical sync and data enable.

The bit-to-colour assignment follows one of two schemes, chosen by a select input. The two schemes differ in whether the fourth lane carries the two lowest or the two highest bits of each colour. A lock state machine confirms the framing over several pixel periods before any pixel is presented. It drops lock after repeated framing errors and then searches again. The pixel outputs are registered, change only once per pixel period, and come with a one-cycle valid strobe.

Top module: `video_deframer`

## Requirements
- R1: On each data lane L (0 to 3), the bit that arrives k-th within a pixel period (k = 0 to 6) becomes frame bit 7*L + k.
- R2: The framing lane, read in arrival order over one pixel period, must be 1,1,0,0,0,1,1. A pixel period starts with the first of the leading two ones.
- R3: With mapSel = 0: red = {f[5:0], f[22:21]}, green = {f[11:6], f[24:23]}, blue = {f[17:12], f[26:25]}, where f is the frame word and the left end of each concatenation is the most significant bit.
- R4: With mapSel = 1: red = {f[22:21], f[5:0]}, green = {f[24:23], f[11:6]}, blue = {f[26:25], f[17:12]}.
- R5: In both schemes hsync = f[18], vsync = f[19] and de = f[20]. Frame bit 27 has no effect on any output.
- R6: locked rises after three consecutive pixel periods with a correct framing shape. It rises on the same edge that presents the third of those frames.
- R7: While locked, one pixel period with a wrong framing shape keeps lock, and that frame is still decoded. A second consecutive wrong period drops lock.
- R8: After lock drops, the search tries every bit offset. The block locks again at a new offset three correct periods later and decodes from that offset.
- R9: While locked is low, red, green, blue, hsync, vsync, de and pixValid are all zero.
- R10: mapSel is sampled once per frame, in the cycle right after the frame's last bit. A change in the middle of a frame does not alter the pixel already on the outputs.
- R11: The decoded pixel appears on the second clock edge after the frame's last bit is sampled, and stays stable until the next pixel. pixValid is high for exactly that one cycle, and only while locked.
- R12: After reset, locked, pixValid and all pixel outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven cycles per pixel |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 4 | One sampled bit from each data lane |
| frameClkIn | input | 1 | Sampled bit of the framing-clock lane |
| mapSel | input | 1 | Colour bit scheme: 0 low bits on lane 3, 1 high bits on lane 3 |
| red | output | 8 | Decoded red channel |
| green | output | 8 | Decoded green channel |
| blue | output | 8 | Decoded blue channel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pixValid | output | 1 | One-cycle strobe when a new pixel is presented |
| locked | output | 1 | Frame alignment held |

## Verification
The bench starts the stream three bits off a pixel boundary. It checks that lock needs exactly three good periods: a counter that is one off would present a pixel one frame early or late. It feeds a lone bad framing period followed by a second one. A design that drops lock on the first miss would blank the output too early, and one that never drops lock would keep showing stale pixels. After a two-bit slip it checks that the block locks again at the new offset, which catches a search that skips offsets. Vectors switch mapSel in the middle of a frame and set the reserved bit. A decoder that reads the select live, or that mixes up the concatenation order of the two schemes, shows wrong colour bits.

// File: rtl/video_deframer_pkg.sv
package video_deframer_pkg;
  localparam int LANE_COUNT = 4;
  localparam int LANE_BITS  = 7;
  localparam int FRAME_W    = LANE_COUNT * LANE_BITS;

  typedef struct packed {
    logic load;   // present decoded frame this edge
    logic clear;  // blank outputs this edge
  } strobe_t;

  typedef enum logic [1:0] {ST_SEARCH, ST_VERIFY, ST_LOCKED} lock_state_t;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
    logic       hsync;
    logic       vsync;
    logic       de;
  } pixel_t;

  function automatic pixel_t decodePixel(input logic [FRAME_W-2:0] f, input logic sel);
    pixel_t p;
    p.hsync = f[18];
    p.vsync = f[19];
    p.de    = f[20];
    if (!sel) begin
      p.red   = {f[5:0],   f[22:21]};
      p.green = {f[11:6],  f[24:23]};
      p.blue  = {f[17:12], f[26:25]};
    end else begin
      p.red   = {f[22:21], f[5:0]};
      p.green = {f[24:23], f[11:6]};
      p.blue  = {f[26:25], f[17:12]};
    end
    return p;
  endfunction
endpackage

// File: rtl/video_deframer_datapath.sv
module video_deframer_datapath
  import video_deframer_pkg::*;
#(
  parameter logic [LANE_BITS-1:0] CLK_SHAPE = 7'b1100011
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LANE_COUNT-1:0] dataIn,
  input  logic                  frameClkIn,
  input  logic                  mapSel,
  input  strobe_t               strobe,
  output logic                  clkMatch,
  output pixel_t                pixOut,
  output logic                  pixValid
);
  logic [LANE_BITS-1:0] laneShift [LANE_COUNT];
  logic [LANE_BITS-1:0] clkShift;
  logic [FRAME_W-1:0]   frameWord;
  logic                 unusedReserved;

  // Newest bit enters at position 0, so the oldest bit of the frame sits at the top.
  genvar gl, gk;
  generate
    for (gl = 0; gl < LANE_COUNT; gl++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rstN) laneShift[gl] <= '0;
        else       laneShift[gl] <= {laneShift[gl][LANE_BITS-2:0], dataIn[gl]};
      end
      for (gk = 0; gk < LANE_BITS; gk++) begin : g_bit
        assign frameWord[gl*LANE_BITS + gk] = laneShift[gl][LANE_BITS-1-gk];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) clkShift <= '0;
    else       clkShift <= {clkShift[LANE_BITS-2:0], frameClkIn};
  end

  assign clkMatch       = (clkShift == CLK_SHAPE);
  assign unusedReserved = frameWord[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      pixValid <= strobe.load;
      if (strobe.load)       pixOut <= decodePixel(frameWord[FRAME_W-2:0], mapSel);
      else if (strobe.clear) pixOut <= '0;
    end
  end

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.clear));
endmodule

// File: rtl/video_deframer_ctrl.sv
module video_deframer_ctrl
  import video_deframer_pkg::*;
#(
  parameter int LOCK_FRAMES = 3,
  parameter int MISS_FRAMES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clkMatch,
  output strobe_t strobe,
  output logic    locked
);
  localparam int RUN_MAX = (LOCK_FRAMES > MISS_FRAMES) ? LOCK_FRAMES : MISS_FRAMES;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int PH_W    = $clog2(LANE_BITS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(LANE_BITS - 1);

  lock_state_t      state, stateNext;
  logic [RUN_W-1:0] runCnt, runNext, runInc;
  logic [PH_W-1:0]  phase, phaseNext;
  logic             tick;

  assign runInc = runCnt + RUN_W'(1);
  // Searching checks every cycle, which walks all seven offsets; otherwise once per frame.
  assign tick   = (state == ST_SEARCH) || (phase == PH_LAST);

  always_comb begin
    stateNext = state;
    runNext   = runCnt;
    phaseNext = (phase == PH_LAST) ? '0 : phase + PH_W'(1);
    unique case (state)
      ST_SEARCH: if (clkMatch) begin
        phaseNext = '0;
        if (LOCK_FRAMES <= 1) begin stateNext = ST_LOCKED; runNext = '0; end
        else                  begin stateNext = ST_VERIFY; runNext = RUN_W'(1); end
      end
      ST_VERIFY: if (tick) begin
        if (!clkMatch)                          begin stateNext = ST_SEARCH; runNext = '0; end
        else if (runInc == RUN_W'(LOCK_FRAMES)) begin stateNext = ST_LOCKED; runNext = '0; end
        else                                    runNext = runInc;
      end
      ST_LOCKED: if (tick) begin
        if (clkMatch)                           runNext = '0;
        else if (runInc == RUN_W'(MISS_FRAMES)) begin stateNext = ST_SEARCH; runNext = '0; end
        else                                    runNext = runInc;
      end
      default: begin stateNext = ST_SEARCH; runNext = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_SEARCH;
      runCnt <= '0;
      phase  <= '0;
    end else begin
      state  <= stateNext;
      runCnt <= runNext;
      phase  <= phaseNext;
    end
  end

  assign strobe.load  = tick && (stateNext == ST_LOCKED);
  assign strobe.clear = tick && (stateNext != ST_LOCKED);
  assign locked       = (state == ST_LOCKED);

  assert_lock_on_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(clkMatch));
  assert_drop_on_miss_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> !$past(clkMatch));
endmodule

// File: rtl/video_deframer.sv
module video_deframer
  import video_deframer_pkg::*;
#(
  parameter int                   LOCK_FRAMES = 3,
  parameter int                   MISS_FRAMES = 2,
  parameter logic [LANE_BITS-1:0] CLK_SHAPE   = 7'b1100011
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LANE_COUNT-1:0] dataIn,
  input  logic                  frameClkIn,
  input  logic                  mapSel,
  output logic [7:0]            red,
  output logic [7:0]            green,
  output logic [7:0]            blue,
  output logic                  hsync,
  output logic                  vsync,
  output logic                  de,
  output logic                  pixValid,
  output logic                  locked
);
  strobe_t strobe;
  logic    clkMatch;
  pixel_t  pixOut;

  video_deframer_ctrl #(.LOCK_FRAMES(LOCK_FRAMES), .MISS_FRAMES(MISS_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkMatch(clkMatch), .strobe(strobe), .locked(locked));

  video_deframer_datapath #(.CLK_SHAPE(CLK_SHAPE)) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .frameClkIn(frameClkIn), .mapSel(mapSel),
    .strobe(strobe), .clkMatch(clkMatch), .pixOut(pixOut), .pixValid(pixValid));

  assign red   = pixOut.red;
  assign green = pixOut.green;
  assign blue  = pixOut.blue;
  assign hsync = pixOut.hsync;
  assign vsync = pixOut.vsync;
  assign de    = pixOut.de;

  assert_blank_unlocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> ({red, green, blue, hsync, vsync, de} == '0 && !pixValid));
  assert_valid_needs_lock_R11: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> locked);
  assert_valid_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);
endmodule

// File: tb/video_deframer_tb.sv
module video_deframer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] dataIn = '0;
  logic       frameClkIn = 1'b0;
  logic       mapSel = 1'b0;
  logic [7:0] red, green, blue;
  logic       hsync, vsync, de, pixValid, locked;

  int checks = 0;
  int failures = 0;
  int validCount = 0;
  bit countOn = 1'b0;

  localparam logic [6:0] GOOD = 7'b1100011;
  localparam logic [6:0] BAD  = 7'b0000000;
  localparam int NVEC = 8;
  // {mapSel, frame word}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 28'h0123456}, {1'b1, 28'hFFFFFFF}, {1'b0, 28'h8ABCDEF}, {1'b1, 28'h8000000},
    {1'b0, 28'h5555555}, {1'b1, 28'hAAAAAAA}, {1'b1, 28'h0000001}, {1'b0, 28'h3C3C3C3}};

  always #4 clk = ~clk;

  video_deframer u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .frameClkIn(frameClkIn), .mapSel(mapSel),
    .red(red), .green(green), .blue(blue), .hsync(hsync), .vsync(vsync), .de(de),
    .pixValid(pixValid), .locked(locked));

  always @(negedge clk) if (countOn && pixValid) validCount++;

  function automatic logic [26:0] expectPix(input logic [27:0] f, input logic sel);
    logic [7:0] r, g, b;
    if (!sel) begin
      r = {f[5:0], f[22:21]};  g = {f[11:6], f[24:23]};  b = {f[17:12], f[26:25]};
    end else begin
      r = {f[22:21], f[5:0]};  g = {f[24:23], f[11:6]};  b = {f[26:25], f[17:12]};
    end
    return {r, g, b, f[18], f[19], f[20]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // R1: lane L, arrival k -> frame bit 7L+k; R10: select changes mid-frame (k=3)
  task automatic sendFrame(input logic [27:0] f, input logic [6:0] shape, input logic sel);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) dataIn[l] = f[7*l + k];
      frameClkIn = shape[6-k];
      if (k == 3) mapSel = sel;
    end
    #1;
  endtask

  task automatic sendSlip(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameClkIn = 1'b0;
      dataIn = 4'hF;
    end
    #1;
  endtask

  function automatic logic [26:0] outPix();
    return {red, green, blue, hsync, vsync, de};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R12 locked", {31'b0, locked}, 0);
    check("R12 pixel", {5'b0, outPix()}, 0);
    check("R12 pixValid", {31'b0, pixValid}, 0);

    sendSlip(3);  // start off a boundary: R2 search
    countOn = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      sendFrame(VEC[i][27:0], GOOD, VEC[i][28]);
      if (i == 2) begin
        check("R6 not yet locked", {31'b0, locked}, 0);
        check("R9 blank before lock", {5'b0, outPix()}, 0);
      end
      if (i >= 3) begin
        check(VEC[i-1][28] ? "R1 R4 R5 decode" : "R1 R3 R5 decode",
              {5'b0, outPix()}, {5'b0, expectPix(VEC[i-1][27:0], VEC[i-1][28])});
        check("R6 locked", {31'b0, locked}, 1);
        if (VEC[i][28] != VEC[i-1][28])
          check("R10 select change mid-frame", {5'b0, outPix()},
                {5'b0, expectPix(VEC[i-1][27:0], VEC[i-1][28])});
      end
    end
    check("R11 pixValid pulses", validCount, NVEC - 3);
    countOn = 1'b0;

    // R7: single miss tolerated, second miss drops
    sendFrame(28'h1234567, GOOD, 1'b0);
    check("R3 decode", {5'b0, outPix()}, {5'b0, expectPix(VEC[NVEC-1][27:0], VEC[NVEC-1][28])});
    sendFrame(28'h0ABCDEF, BAD, 1'b0);
    check("R7 locked before miss", {31'b0, locked}, 1);
    sendFrame(28'h7654321, BAD, 1'b0);
    check("R7 one miss keeps lock", {31'b0, locked}, 1);
    check("R7 missed frame decoded", {5'b0, outPix()}, {5'b0, expectPix(28'h0ABCDEF, 1'b0)});
    sendFrame(28'h2468ACE, BAD, 1'b0);
    check("R7 second miss drops lock", {31'b0, locked}, 0);
    check("R9 blank after drop", {5'b0, outPix()}, 0);

    // R8: relock at a new offset
    sendSlip(2);
    sendFrame(28'h1111111, GOOD, 1'b1);
    sendFrame(28'h2222222, GOOD, 1'b1);
    sendFrame(28'h0F0F0F0, GOOD, 1'b1);
    check("R8 not locked after two", {31'b0, locked}, 0);
    sendFrame(28'h4444444, GOOD, 1'b1);
    check("R8 relocked", {31'b0, locked}, 1);
    check("R8 R4 decode at new offset", {5'b0, outPix()}, {5'b0, expectPix(28'h0F0F0F0, 1'b1)});
    finishRun();
  end
endmodule